// File: doc/BRIEF.md
# UART Register File with Prioritized Interrupts

This block is the software-visible face of a byte-wide serial port. It decodes a 32-bit, word-accessed register bus and connects it to an external serial datapath. On the receive side the datapath offers one byte with a valid pulse, and the block answers with a ready level. On the transmit side the block emits one byte with a valid pulse for each write to the data register. There is no receive FIFO. One byte is held, and the data-ready flag that marks it is also the backpressure signal toward the receiver.

Parity, framing and break errors arrive as one-cycle pulses, and the block latches them into the line status word. Four interrupt sources combine under a fixed ranking into one level interrupt and a 3-bit identification code. Both are recomputed combinationally from the current flags and enables.

Each register is 32 bits wide and sits at byte offset index × 4. Byte address bits [1:0] are ignored. The registers by index:
- 0: data. A read returns the held byte; a write transmits.
- 1: interrupt enable, bits [3:0].
- 2: interrupt identification, read-only.
- 3: line control, 8-bit storage.
- 4: modem control, 8-bit storage.
- 5: line status, read-only.
- 6: modem status, read-only. It is a registered copy of an 8-bit input.
- 7: unmapped.

Top module: `uart_regs`

## Requirements
- R1: After reset, line status reads 0x60 (transmit-holding-empty bit 5 and transmitter-empty bit 6 set), the interrupt enable reads 0, identification reads 0x01, `irq` is low and `rxReady` is high.
- R2: A bus read of index 0 returns the held byte in bits [7:0]. Its edge clears data-ready (line status bit 0), which is observable as `rxReady` returning high.
- R3: `rxReady` is high exactly while data-ready is clear. A byte accepted with `rxValid` sets data-ready in the next cycle.
- R4: A byte that arrives while data-ready is set, with no data read in the same cycle, sets overrun (line status bit 1). That byte is dropped and the held byte is kept.
- R5: A bus write to index 0 produces exactly one `txValid` pulse in the following cycle, with `txByte` equal to write data bits [7:0]. No other access produces a pulse.
- R6: A pulse on `parityErr`, `frameErr` or `breakErr` sets line status bit 2, 3 or 4 respectively. A read of line status returns the flags and then clears bits 1 to 4. A new error pulse in the same cycle as that read wins.
- R7: Interrupt enable bits are: bit 0 for receive data, bit 1 for transmit holding empty, bit 2 for line error, bit 3 for modem status. The highest-ranked enabled pending source sets identification bits [2:1], in this rank order:
  - line error (any of line status bits 1 to 4): 0b11
  - receive data ready: 0b10
  - transmit holding empty: 0b01
  - modem status: 0b00
- R8: With no enabled source pending, identification reads 0x01 (bit 0 = no interrupt pending) and `irq` is low. Otherwise bit 0 is 0 and `irq` is high.
- R9: A modem status interrupt is pending when any of modem status bits [3:0] is set. Bits [7:4] never raise one.
- R10: Writes to indices 2, 5 and 6 are ignored. Reads of index 7 return 0.
- R11: Indices 1, 3 and 4 read back the last value written, masked to the register width: 4 bits for index 1, 8 bits for indices 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 5 | Byte address; bits [4:2] select the register |
| busWr | input | 1 | Word write strobe |
| busRd | input | 1 | Word read strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational, valid while busRd is high |
| rxValid | input | 1 | Received byte valid pulse |
| rxByte | input | 8 | Received byte |
| rxReady | output | 1 | High while no unread byte is held |
| txValid | output | 1 | Transmit byte valid pulse |
| txByte | output | 8 | Transmit byte |
| parityErr | input | 1 | Parity error pulse |
| frameErr | input | 1 | Framing error pulse |
| breakErr | input | 1 | Break detected pulse |
| modemStat | input | 8 | Modem status level, registered into index 6 |
| irq | output | 1 | Level interrupt |

## Verification
The overrun property assumes that a byte offered against a low `rxReady` is a deliberate protocol violation. The bench produces that case only in the overrun scenario, with no data read in the same cycle. The other assertions assume single-cycle bus strobes, with read and write never high together. The bench keeps to this by driving every access for exactly one cycle, followed by an idle cycle. Error pulses and modem status changes are applied between bus accesses, so no assertion window sees a coincident line status read.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned IDX_W  = 3;
  localparam int unsigned IEN_W  = 4;

  localparam logic [IDX_W-1:0] IDX_DATA = 3'd0;
  localparam logic [IDX_W-1:0] IDX_IEN  = 3'd1;
  localparam logic [IDX_W-1:0] IDX_IID  = 3'd2;
  localparam logic [IDX_W-1:0] IDX_LCTL = 3'd3;
  localparam logic [IDX_W-1:0] IDX_MCTL = 3'd4;
  localparam logic [IDX_W-1:0] IDX_LSTS = 3'd5;
  localparam logic [IDX_W-1:0] IDX_MSTS = 3'd6;

  typedef struct packed {
    logic dataRd;
    logic dataWr;
    logic ienWr;
    logic lctlWr;
    logic mctlWr;
    logic lstsRd;
  } strobes_t;
endpackage

// File: rtl/uart_regs_ctrl.sv
module uart_regs_ctrl
  import uart_regs_pkg::*;
(
  input  logic [IDX_W-1:0]  idx,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [BYTE_W-1:0] lsts,
  input  logic [IEN_W-1:0]  ien,
  input  logic [BYTE_W-1:0] msts,
  output strobes_t          stb,
  output logic [2:0]        iid,
  output logic              irq
);
  always_comb begin
    stb        = '0;
    stb.dataRd = busRd && (idx == IDX_DATA);
    stb.lstsRd = busRd && (idx == IDX_LSTS);
    stb.dataWr = busWr && (idx == IDX_DATA);
    stb.ienWr  = busWr && (idx == IDX_IEN);
    stb.lctlWr = busWr && (idx == IDX_LCTL);
    stb.mctlWr = busWr && (idx == IDX_MCTL);
  end

  logic lineHit, rxHit, txHit, modemHit;
  assign lineHit  = (|lsts[4:1]) && ien[2];
  assign rxHit    = lsts[0] && ien[0];
  assign txHit    = lsts[5] && ien[1];
  assign modemHit = (|msts[3:0]) && ien[3];

  always_comb begin
    if (lineHit)       iid = 3'b110;
    else if (rxHit)    iid = 3'b100;
    else if (txHit)    iid = 3'b010;
    else if (modemHit) iid = 3'b000;
    else               iid = 3'b001;
  end

  assign irq = lineHit || rxHit || txHit || modemHit;
endmodule

// File: rtl/uart_regs_dp.sv
module uart_regs_dp
  import uart_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [IDX_W-1:0]  idx,
  input  logic              busRd,
  input  logic [BUS_W-1:0]  busWdata,
  input  logic [2:0]        iid,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              parityErr,
  input  logic              frameErr,
  input  logic              breakErr,
  input  logic [BYTE_W-1:0] modemStat,
  output logic [BUS_W-1:0]  busRdata,
  output logic              txValid,
  output logic [BYTE_W-1:0] txByte,
  output logic [BYTE_W-1:0] lsts,
  output logic [IEN_W-1:0]  ien,
  output logic [BYTE_W-1:0] msts
);
  logic [BYTE_W-1:0] rxHold, lctl, mctl;
  logic dataReady, overrun, parityF, frameF, breakF;
  logic accept, ovf;

  assign accept = rxValid && (!dataReady || stb.dataRd);
  assign ovf    = rxValid && dataReady && !stb.dataRd;
  assign lsts   = {1'b0, 1'b1, 1'b1, breakF, frameF, parityF, overrun, dataReady};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxHold    <= '0;
      lctl      <= '0;
      mctl      <= '0;
      ien       <= '0;
      msts      <= '0;
      dataReady <= 1'b0;
      overrun   <= 1'b0;
      parityF   <= 1'b0;
      frameF    <= 1'b0;
      breakF    <= 1'b0;
      txValid   <= 1'b0;
      txByte    <= '0;
    end else begin
      msts <= modemStat;
      if (accept) begin
        rxHold    <= rxByte;
        dataReady <= 1'b1;
      end else if (stb.dataRd) begin
        dataReady <= 1'b0;
      end
      overrun <= (overrun && !stb.lstsRd) || ovf;
      parityF <= (parityF && !stb.lstsRd) || parityErr;
      frameF  <= (frameF  && !stb.lstsRd) || frameErr;
      breakF  <= (breakF  && !stb.lstsRd) || breakErr;
      if (stb.ienWr)  ien  <= busWdata[IEN_W-1:0];
      if (stb.lctlWr) lctl <= busWdata[BYTE_W-1:0];
      if (stb.mctlWr) mctl <= busWdata[BYTE_W-1:0];
      txValid <= stb.dataWr;
      if (stb.dataWr) txByte <= busWdata[BYTE_W-1:0];
    end
  end

  always_comb begin
    busRdata = '0;
    if (busRd) begin
      case (idx)
        IDX_DATA: busRdata[BYTE_W-1:0] = rxHold;
        IDX_IEN:  busRdata[IEN_W-1:0]  = ien;
        IDX_IID:  busRdata[2:0]        = iid;
        IDX_LCTL: busRdata[BYTE_W-1:0] = lctl;
        IDX_MCTL: busRdata[BYTE_W-1:0] = mctl;
        IDX_LSTS: busRdata[BYTE_W-1:0] = lsts;
        IDX_MSTS: busRdata[BYTE_W-1:0] = msts;
        default:  busRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/uart_regs.sv
module uart_regs
  import uart_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxByte,
  output logic              rxReady,
  output logic              txValid,
  output logic [BYTE_W-1:0] txByte,
  input  logic              parityErr,
  input  logic              frameErr,
  input  logic              breakErr,
  input  logic [BYTE_W-1:0] modemStat,
  output logic              irq
);
  localparam int unsigned IDX_LO = 2;

  logic [IDX_W-1:0]  idx;
  strobes_t          stb;
  logic [2:0]        iid;
  logic [BYTE_W-1:0] lsts, msts;
  logic [IEN_W-1:0]  ien;

  assign idx     = busAddr[IDX_LO +: IDX_W];
  assign rxReady = !lsts[0];

  uart_regs_ctrl u_ctrl (
    .idx(idx), .busRd(busRd), .busWr(busWr), .lsts(lsts), .ien(ien),
    .msts(msts), .stb(stb), .iid(iid), .irq(irq)
  );

  uart_regs_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .idx(idx), .busRd(busRd),
    .busWdata(busWdata), .iid(iid), .rxValid(rxValid), .rxByte(rxByte),
    .parityErr(parityErr), .frameErr(frameErr), .breakErr(breakErr),
    .modemStat(modemStat), .busRdata(busRdata), .txValid(txValid),
    .txByte(txByte), .lsts(lsts), .ien(ien), .msts(msts)
  );
endmodule

// File: rtl/uart_regs_chk.sv
module uart_regs_chk #(
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRd,
  input logic              busWr,
  input logic [31:0]       busWdata,
  input logic              rxValid,
  input logic              rxReady,
  input logic              txValid,
  input logic [7:0]        txByte,
  input logic              irq,
  input logic [2:0]        iid,
  input logic [7:0]        lsts,
  input logic [3:0]        ien,
  input logic [7:0]        msts
);
  logic atData;
  assign atData = (busAddr[ADDR_W-1:2] == '0);

  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxReady) |=> !rxReady);

  a_r2_clear: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && atData && !rxValid) |=> rxReady);

  a_r4_overrun: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady && !(busRd && atData)) |=> lsts[1]);

  a_r5_tx: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && atData) |=> (txValid && txByte == $past(busWdata[7:0])));

  a_r5_notx: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && atData) |=> !txValid);

  a_r7_line: assert property (@(posedge clk) disable iff (!rstN)
    ((|lsts[4:1]) && ien[2]) |-> (iid == 3'b110));

  a_r8_level: assert property (@(posedge clk) disable iff (!rstN)
    irq == !iid[0]);

  a_r9_modem: assert property (@(posedge clk) disable iff (!rstN)
    ((|msts[3:0]) && ien[3]) |-> irq);
endmodule

bind uart_regs uart_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
  .busWdata(busWdata), .rxValid(rxValid), .rxReady(rxReady),
  .txValid(txValid), .txByte(txByte), .irq(irq), .iid(iid), .lsts(lsts),
  .ien(ien), .msts(msts)
);

// File: tb/uart_regs_bench.sv
`timescale 1ns/1ps
module uart_regs_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] busAddr = '0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic rxValid = 1'b0;
  logic [7:0] rxByte = '0;
  logic rxReady, txValid;
  logic [7:0] txByte;
  logic parityErr = 1'b0, frameErr = 1'b0, breakErr = 1'b0;
  logic [7:0] modemStat = '0;
  logic irq;

  int checks = 0;
  int errors = 0;
  int unsigned rdExp[$];
  string rdTag[$];
  int unsigned txExp[$];

  always #2 clk = ~clk;

  uart_regs u_uart_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .rxValid(rxValid),
    .rxByte(rxByte), .rxReady(rxReady), .txValid(txValid), .txByte(txByte),
    .parityErr(parityErr), .frameErr(frameErr), .breakErr(breakErr),
    .modemStat(modemStat), .irq(irq)
  );

  task automatic check(input string tag, input int unsigned act, input int unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: compares read data and transmit bytes against the scoreboard.
  always @(negedge clk) begin
    #1;
    if (busRd) begin
      if (rdExp.size() == 0) check("R10 unexpected read", 1, 0);
      else check(rdTag.pop_front(), busRdata, rdExp.pop_front());
    end
    if (txValid) begin
      if (txExp.size() == 0) check("R5 unexpected txValid", 1, 0);
      else check("R5 txByte", txByte, txExp.pop_front());
    end
  end

  task automatic wr(input int idx, input int unsigned d);
    @(negedge clk);
    busAddr = 5'(idx * 4); busWdata = d; busWr = 1'b1;
    if (idx == 0) txExp.push_back(d & 32'hFF);
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input int idx, input int unsigned exp, input string tag);
    @(negedge clk);
    busAddr = 5'(idx * 4); busRd = 1'b1;
    rdExp.push_back(exp); rdTag.push_back(tag);
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic rx(input logic [7:0] b);
    @(negedge clk);
    rxValid = 1'b1; rxByte = b;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: parityErr = 1'b1;
      1: frameErr = 1'b1;
      default: breakErr = 1'b1;
    endcase
    @(negedge clk);
    parityErr = 1'b0; frameErr = 1'b0; breakErr = 1'b0;
  endtask

  task automatic pins(input string tag, input logic expIrq, input logic expReady);
    #1;
    check({tag, " irq"}, irq, expIrq);
    check({tag, " rxReady"}, rxReady, expReady);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    pins("R1 reset", 1'b0, 1'b1);
    rd(5, 32'h60, "R1 line status");
    rd(1, 32'h0, "R1 enable");
    rd(2, 32'h1, "R1 ident");
    check("R5 no tx after reset", txExp.size(), 0);

    // Receive path
    wr(1, 32'h1);
    pins("R8 enabled idle", 1'b0, 1'b1);
    rx(8'hA5);
    pins("R3 byte held", 1'b1, 1'b0);
    rd(2, 32'h4, "R7 rx ident");
    rd(0, 32'hA5, "R2 data");
    pins("R2 cleared", 1'b0, 1'b1);
    rd(2, 32'h1, "R8 none pending");

    // Overrun: second byte offered while data-ready is set
    wr(1, 32'h0);
    rx(8'h11);
    rx(8'h22);
    rd(5, 32'h63, "R4 overrun flag");
    rd(5, 32'h61, "R6 cleared on read");
    rd(0, 32'h11, "R4 byte kept");

    // Priority ranking
    wr(1, 32'hF);
    modemStat = 8'h01;
    pulse(0);
    rx(8'h5A);
    rd(2, 32'h6, "R7 line over all");
    rd(5, 32'h65, "R6 parity flag");
    rd(2, 32'h4, "R7 rx over tx");
    rd(0, 32'h5A, "R2 data two");
    rd(2, 32'h2, "R7 tx over modem");
    wr(1, 32'h8);
    rd(2, 32'h0, "R9 modem ident");
    pins("R9 modem irq", 1'b1, 1'b1);
    modemStat = 8'hF0;
    repeat (2) @(negedge clk);
    pins("R9 high bits no irq", 1'b0, 1'b1);
    rd(6, 32'hF0, "R9 modem status");
    modemStat = 8'h00;

    // Framing and break flags
    wr(1, 32'h4);
    pulse(1);
    pins("R6 frame irq", 1'b1, 1'b1);
    rd(5, 32'h68, "R6 frame flag");
    pulse(2);
    rd(5, 32'h70, "R6 break flag");
    rd(2, 32'h1, "R8 after clear");

    // Transmit
    wr(0, 32'h123456C3);
    wr(0, 32'h000000FF);
    wr(1, 32'h0);
    repeat (2) @(negedge clk);
    check("R5 all tx consumed", txExp.size(), 0);

    // Ignored accesses and readback
    wr(5, 32'hFF);
    wr(2, 32'hFF);
    wr(6, 32'hFF);
    rd(5, 32'h60, "R10 line status write ignored");
    rd(2, 32'h1, "R10 ident write ignored");
    rd(6, 32'h0, "R10 modem status write ignored");
    rd(7, 32'h0, "R10 unmapped reads zero");
    wr(3, 32'hFFFFFFAB);
    wr(4, 32'h0000005C);
    wr(1, 32'hFFFFFFF2);
    rd(3, 32'hAB, "R11 line control");
    rd(4, 32'h5C, "R11 modem control");
    rd(1, 32'h2, "R11 enable masked");
    pins("R7 tx empty irq", 1'b1, 1'b1);

    repeat (2) @(negedge clk);
    check("R10 scoreboard drained", rdExp.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule